// File: doc/BRIEF.md
# Pulse-Shaping Interpolating FIR

This block sits at the front of a baseband transmit chain. It accepts one signed 8-bit symbol, either +1 or -1, at each input strobe. For every accepted symbol it produces four samples at four times the symbol rate. The first of the four is the symbol itself. The other three are either zeros or copies of the symbol, depending on a mode input that is captured when the symbol is accepted. Each new sample goes through a fixed, symmetric 9-tap integer low-pass kernel. The kernel narrows the spectrum before the next interpolation stage.

Everything runs on one fast system clock. With the default parameters the clock is 80 MHz, one symbol arrives every 80 cycles, and one filtered sample leaves every 20 cycles. Only the input strobe starts a symbol period. A control unit counts the sub-sample slots after each accepted symbol and drives the delay-line shift and the output load as strobes. The mirrored taps of the kernel are pre-added, so each output needs five multiplications.

Top module: `pulse_shape_interp`

## Requirements
- R1: While `rst` is high at a rising edge, `outValid` and `outData` are cleared to 0 and the delay line is emptied. The first outputs after reset therefore depend only on symbols accepted after reset.
- R2: A symbol presented with `symValid` high at a rising edge enters the delay line at that edge. The matching output appears with `outValid` high in the cycle after the following rising edge.
- R3: Each accepted symbol yields exactly four output strobes, `CLK_PER_OUT` (20) cycles apart. After the fourth, `outValid` stays low until the next accepted symbol.
- R4: With `holdMode` = 1 at acceptance, the three samples that follow the symbol each equal the symbol (zero-order hold).
- R5: With `holdMode` = 0 at acceptance, the three samples that follow the symbol are zero (zero-stuffing).
- R6: Every output equals sum over k = 0..8 of c[k]·x[n−k]. Here x[n] is the newest sample in the delay line and c = {0, 17, 38, 57, 64, 57, 38, 17, 0}.
- R7: `outData` is signed 16-bit two's complement. For ±1 input its magnitude never exceeds 288.
- R8: A symbol accepted before the four samples of the previous symbol are complete restarts the slot count. The previous symbol's remaining samples are dropped.
- R9: A change of `holdMode` after acceptance has no effect on the samples of the symbol already accepted.
- R10: `outData` changes only on the cycle in which `outValid` is high, and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| symValid | input | 1 | Symbol strobe, one cycle wide |
| symIn | input | 8 | Signed symbol, +1 (0x01) or -1 (0xFF) |
| holdMode | input | 1 | 1 = repeat the symbol in fill slots, 0 = insert zeros |
| outData | output | 16 | Signed filtered sample |
| outValid | output | 1 | Output strobe, one cycle wide |

## Verification
The bench targets three corner cases.
- Mode switch after acceptance: a design that read `holdMode` live would mix held and zero samples within one symbol, which breaks R9.
- New symbol halfway through a period: a design without restart would emit stale fill samples or misplace strobes, which breaks R8.
- Mid-stream reset: a design that did not clear the delay line would leak old symbols into the first convolution results, which breaks R1.

A mirrored tap pair added with the wrong index shows up as wrong values under random ±1 streams in both modes. An off-by-one slot counter shows up as strobes at the wrong spacing or as a fifth strobe.

// File: rtl/pshape_pkg.sv
package pshape_pkg;
  parameter int SYM_W       = 8;
  parameter int OUT_W       = 16;
  parameter int NUM_TAPS    = 9;
  parameter int UPS_FACTOR  = 4;
  parameter int CLK_PER_OUT = 20;

  typedef struct packed {
    logic shift;    // push a new sample into the delay line
    logic outLoad;  // register the convolution result
  } pshapeStrb_t;

  function automatic int tapCoef(input int idx);
    case (idx)
      0, 8:    return 0;
      1, 7:    return 17;
      2, 6:    return 38;
      3, 5:    return 57;
      4:       return 64;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/pshape_ctrl.sv
module pshape_ctrl
  import pshape_pkg::*;
#(
  parameter int SW     = SYM_W,
  parameter int UPS    = UPS_FACTOR,
  parameter int SUBCLK = CLK_PER_OUT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 symValid,
  input  logic signed [SW-1:0] symIn,
  input  logic                 holdMode,
  output pshapeStrb_t          strb,
  output logic signed [SW-1:0] sampleOut
);
  localparam int SUB_W  = $clog2(SUBCLK);
  localparam int FILL_W = $clog2(UPS);

  logic                 active;
  logic [SUB_W-1:0]     subCnt;
  logic [FILL_W-1:0]    fillCnt;
  logic signed [SW-1:0] heldSym;
  logic                 heldMode;
  logic                 loadQ;
  logic                 fillSlot;

  assign fillSlot = active && (subCnt == SUB_W'(SUBCLK - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      subCnt   <= '0;
      fillCnt  <= '0;
      heldSym  <= '0;
      heldMode <= 1'b0;
      loadQ    <= 1'b0;
    end else begin
      loadQ <= symValid || fillSlot;
      if (symValid) begin
        active   <= 1'b1;
        subCnt   <= '0;
        fillCnt  <= '0;
        heldSym  <= symIn;
        heldMode <= holdMode;
      end else if (active) begin
        if (fillSlot) begin
          subCnt  <= '0;
          fillCnt <= fillCnt + 1'b1;
          if (fillCnt == FILL_W'(UPS - 2)) active <= 1'b0;
        end else begin
          subCnt <= subCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.shift   = symValid || fillSlot;
    strb.outLoad = loadQ;
    if (symValid)      sampleOut = symIn;
    else if (heldMode) sampleOut = heldSym;
    else               sampleOut = '0;
  end
endmodule

// File: rtl/pshape_datapath.sv
module pshape_datapath
  import pshape_pkg::*;
#(
  parameter int SW   = SYM_W,
  parameter int OW   = OUT_W,
  parameter int NTAP = NUM_TAPS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pshapeStrb_t          strb,
  input  logic signed [SW-1:0] sampleIn,
  output logic signed [OW-1:0] outData,
  output logic                 outValid
);
  localparam int NPAIR = NTAP / 2;
  localparam int ODD   = NTAP % 2;
  localparam int ACC_W = OW + 2;
  localparam int NPROD = NPAIR + ODD;

  logic signed [SW-1:0]    dl [NTAP];
  logic signed [ACC_W-1:0] prod [NPROD];
  logic signed [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAP; i++) dl[i] <= '0;
    end else if (strb.shift) begin
      dl[0] <= sampleIn;
      for (int i = 1; i < NTAP; i++) dl[i] <= dl[i-1];
    end
  end

  for (genvar g = 0; g < NPAIR; g++) begin : gPair
    localparam logic signed [ACC_W-1:0] COEF = ACC_W'(tapCoef(g));
    logic signed [SW:0] pairSum;
    assign pairSum = SW'(dl[g]) + SW'(dl[NTAP-1-g]) + (SW+1)'(0);
    assign prod[g] = ACC_W'(pairSum) * COEF;
  end

  if (ODD == 1) begin : gCenter
    localparam logic signed [ACC_W-1:0] CCOEF = ACC_W'(tapCoef(NPAIR));
    assign prod[NPAIR] = ACC_W'(dl[NPAIR]) * CCOEF;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NPROD; i++) acc = acc + prod[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.outLoad;
      if (strb.outLoad) outData <= OW'(acc);
    end
  end
endmodule

// File: rtl/pulse_shape_interp.sv
module pulse_shape_interp
  import pshape_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    symValid,
  input  logic signed [SYM_W-1:0] symIn,
  input  logic                    holdMode,
  output logic signed [OUT_W-1:0] outData,
  output logic                    outValid
);
  pshapeStrb_t             strb;
  logic signed [SYM_W-1:0] sample;

  pshape_ctrl #(.SW(SYM_W), .UPS(UPS_FACTOR), .SUBCLK(CLK_PER_OUT)) uCtrl (
    .clk(clk), .rst(rst), .symValid(symValid), .symIn(symIn),
    .holdMode(holdMode), .strb(strb), .sampleOut(sample)
  );

  pshape_datapath #(.SW(SYM_W), .OW(OUT_W), .NTAP(NUM_TAPS)) uPath (
    .clk(clk), .rst(rst), .strb(strb), .sampleIn(sample),
    .outData(outData), .outValid(outValid)
  );
endmodule

// File: rtl/pshape_checker.sv
module pshape_checker #(
  parameter int OW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 symValid,
  input logic signed [OW-1:0] outData,
  input logic                 outValid
);
  // R1: reset clears the output strobe and data
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!outValid && outData == '0));

  // R2: an accepted symbol produces a strobe two edges later
  assert_sym_latency_R2: assert property (@(posedge clk) disable iff (rst)
    symValid |=> ##1 outValid);

  // R7: magnitude bound for +/-1 input
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ($signed(outData) <= 288 && $signed(outData) >= -288));

  // R10: data holds between strobes
  assert_hold_data_R10: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outData));
endmodule

bind pulse_shape_interp pshape_checker #(.OW(pshape_pkg::OUT_W)) uChk (
  .clk(clk), .rst(rst), .symValid(symValid),
  .outData(outData), .outValid(outValid)
);

// File: tb/sim_pulse_shape_interp.sv
`timescale 1ns/1ps
module sim_pulse_shape_interp;
  localparam int SUBC = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              symValid = 1'b0;
  logic signed [7:0] symIn = '0;
  logic              holdMode = 1'b0;
  logic signed [15:0] outData;
  logic              outValid;

  int checks = 0;
  int errors = 0;
  int hist [9];
  int coefs [9] = '{0, 17, 38, 57, 64, 57, 38, 17, 0};
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pulse_shape_interp u0 (
    .clk(clk), .rst(rst), .symValid(symValid), .symIn(symIn),
    .holdMode(holdMode), .outData(outData), .outValid(outValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void clearHist();
    for (int i = 0; i < 9; i++) hist[i] = 0;
  endfunction

  function automatic void pushHist(input int v);
    for (int i = 8; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = v;
  endfunction

  function automatic int refOut();
    int s = 0;
    for (int k = 0; k < 9; k++) s += coefs[k] * hist[k];
    return s;
  endfunction

  task automatic checkSample(input string req);
    int e;
    e = refOut();
    check(outValid == 1'b1, "R3 strobe", int'(outValid), 1);
    check(int'(outData) == e, req, int'(outData), e);
    check(int'(outData) <= 288 && int'(outData) >= -288, "R7", int'(outData), 288);
  endtask

  task automatic idle(input int n);
    int stray = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (outValid) stray++;
    end
    check(stray == 0, "R3 idle", stray, 0);
  endtask

  task automatic sendSym(input logic signed [7:0] s, input bit mode,
                         input int nOut, input bit flip);
    string fillTag;
    fillTag = mode ? "R4 hold" : "R5 zero";
    if (flip) fillTag = {fillTag, " R9"};
    @(negedge clk);
    symValid = 1'b1; symIn = s; holdMode = mode;
    pushHist(int'(s));
    @(negedge clk);
    symValid = 1'b0;
    if (flip) holdMode = !mode;
    @(negedge clk);
    check(outValid == 1'b1, "R2 latency", int'(outValid), 1);
    check(int'(outData) == refOut(), "R6 symbol", int'(outData), refOut());
    for (int j = 1; j < nOut; j++) begin
      idle(SUBC - 1);
      @(negedge clk);
      pushHist(mode ? int'(s) : 0);
      checkSample(fillTag);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; symValid = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 valid", int'(outValid), 0);
    check(outData == '0, "R1 data", int'(outData), 0);
    rst = 1'b0;
    clearHist();
  endtask

  function automatic logic signed [7:0] rndSym();
    return ($urandom % 2) ? 8'sd1 : -8'sd1;
  endfunction

  initial begin
    #(2000000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    clearHist();
    doReset();
    // directed: constant +1 in hold mode reaches the full kernel sum 288
    for (int i = 0; i < 3; i++) begin sendSym(8'sd1, 1'b1, 4, 1'b0); idle(17); end
    // directed: alternating -1/+1 in zero-stuff mode
    for (int i = 0; i < 4; i++) begin
      sendSym((i % 2) ? 8'sd1 : -8'sd1, 1'b0, 4, 1'b0); idle(17);
    end
    // random streams, random mode, some mid-symbol mode flips
    for (int i = 0; i < 30; i++) begin
      sendSym(rndSym(), bit'($urandom % 2), 4, bit'(($urandom % 4) == 0));
      idle(17);
    end
    // R8: restart after two outputs, then a normal symbol
    sendSym(-8'sd1, 1'b1, 2, 1'b0);
    sendSym(8'sd1, 1'b1, 2, 1'b0);
    sendSym(-8'sd1, 1'b0, 4, 1'b0);
    idle(17);
    check(outValid == 1'b0, "R8 after restart", int'(outValid), 0);
    // R1: reset mid-stream, history must be gone
    sendSym(-8'sd1, 1'b1, 2, 1'b0);
    doReset();
    for (int i = 0; i < 6; i++) begin
      sendSym(rndSym(), bit'($urandom % 2), 4, 1'b1);
      idle(17);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule